// File: doc/BRIEF.md
# Time-Staggered Nibble-Slice ALU

This block is a 32-bit integer ALU split into eight 4-bit slices. The slices do not all start at once. Slice k starts one clock after slice k-1, so the operands enter the datapath in diagonal form. Each slice is a pipeline eight stages deep. A slice hands its registered carry to the next, more significant slice exactly when that slice begins. Each slice can also loop its own finished result nibble back to either of its operand inputs. A dependent operation can therefore start as soon as the least significant nibble of its producer is ready. It does not have to wait for the whole 32-bit word, so dependent operations issue eight cycles apart and independent ones every cycle.

The caller presents the opcode, two 32-bit operands and one forward-select bit per operand, qualified by a valid strobe. Two result views are provided. The first is a staggered one, nibble by nibble, with a valid bit per slice. The second is a word-aligned one from a de-skew stage. The word-aligned view also resolves the set-less-than and equality flags and the final carry.

Top module: `bsk_alu`

## Requirements
- R1: Slice k takes operand bits [4k+3:4k], the opcode and both forward selects k cycles after slice 0 does. `skew_vld_o[k]` and `skew_res_o[4k+3:4k]` carry that operation's raw result nibble 8+k clock edges after the issue edge. The raw result is a+b for ADD, a-b for SUB, SLT and EQ, and the bitwise result for the logic operations.
- R2: `vld_o` is high exactly 16 clock edges after each edge that samples `vld_i` high, and low otherwise.
- R3: Independent operations may be issued on every cycle. Each one yields exactly one word-aligned result, in issue order.
- R4: Opcode encoding is 0 ADD, 1 SUB, 2 SLT, 3 EQ, 4 AND, 5 OR, 6 XOR, 7 NOR. For ADD and SUB, `res_o` is the modulo-2^32 sum or difference. For AND, OR, XOR and NOR it is the bitwise result (NOR is ~(a|b)).
- R5: For SLT, `res_o` bit 0 is 1 when a is less than b as signed 32-bit values, including the cases where a-b overflows. Bits 31:1 are zero.
- R6: For EQ, `res_o` bit 0 is 1 when a equals b. Bits 31:1 are zero.
- R7: `cout_o` is bit 32 of a+b for ADD, and bit 32 of a+~b+1 for SUB, SLT and EQ. It is 0 for the logic operations.
- R8: With `fwd_a_i` (or `fwd_b_i`) set, operand a (or b) is replaced by the raw result of the operation issued exactly 8 cycles earlier, and the port value is ignored. For an SLT or EQ producer, the forwarded value is its difference a-b.
- R9: A carry ripples correctly through all eight staggered slices. For example, ADD of 0xFFFFFFFF and 1 gives 0 with `cout_o` = 1.
- R10: Reset is synchronous and active low. While it is applied, `vld_o`, `skew_vld_o` and `res_o` read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| vld_i | input | 1 | Issue strobe |
| op_i | input | 3 | Opcode (encoding in R4) |
| fwd_a_i | input | 1 | Take operand a from the slice's own result |
| fwd_b_i | input | 1 | Take operand b from the slice's own result |
| a_i | input | 32 | Operand a |
| b_i | input | 32 | Operand b |
| skew_vld_o | output | 8 | Per-slice result valid, staggered |
| skew_res_o | output | 32 | Per-slice raw result nibbles, staggered |
| vld_o | output | 1 | Word-aligned result valid |
| res_o | output | 32 | Word-aligned result with flags resolved |
| cout_o | output | 1 | Final carry of the most significant slice |

## Verification
The assertions take for granted that reset is held for at least two edges, so every valid register has a defined previous value. They also assume `vld_i` is never unknown once reset is released. Forwarding is only defined when a valid producer was issued exactly eight cycles earlier. The bench tracks its own issue history and raises a forward select only when that history shows such a producer. Reset is held for four edges before any stimulus.

// File: rtl/bsk_alu_pkg.sv
// Shared opcode type and opcode classification helpers for the staggered ALU.
// Assumes a 3-bit opcode. Bit 2 clear selects an adder operation.
package bsk_alu_pkg;

    typedef enum logic [2:0] {
        OP_ADD = 3'd0,
        OP_SUB = 3'd1,
        OP_SLT = 3'd2,
        OP_EQ  = 3'd3,
        OP_AND = 3'd4,
        OP_OR  = 3'd5,
        OP_XOR = 3'd6,
        OP_NOR = 3'd7
    } alu_op_e;

    // True when the operation runs through the adder.
    function automatic logic op_uses_adder(alu_op_e op);
        return op inside {OP_ADD, OP_SUB, OP_SLT, OP_EQ};
    endfunction

    // True when operand b is inverted and a carry of one is injected.
    function automatic logic op_inverts_b(alu_op_e op);
        return op inside {OP_SUB, OP_SLT, OP_EQ};
    endfunction

endpackage

// File: rtl/bsk_skew_line.sv
// Fixed-length delay line used both to stagger operands and to re-align results.
// Assumes STAGES >= 1. A zero-length path is wired directly by the caller.
module bsk_skew_line #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);

    logic [WIDTH-1:0] sr_q [STAGES];

    // Shift the word one position per clock and clear the line on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) sr_q[i] <= '0;
        end else begin
            sr_q[0] <= d;
            for (int i = 1; i < STAGES; i++) sr_q[i] <= sr_q[i-1];
        end
    end

    assign q = sr_q[STAGES-1];

endmodule

// File: rtl/bsk_alu_slice.sv
// One nibble slice of the staggered ALU.
// It computes in its first stage, using the carry handed over by the previous
// slice in that same cycle. The result then travels down DEPTH pipeline
// registers. The tail of the pipe is both the slice output and the forwarding
// source, so an operation issued DEPTH cycles later can consume it.
// The carry toward the next slice is registered once (the fast copy). The
// final carry rides the pipe with the result (the delayed copy).
module bsk_alu_slice
    import bsk_alu_pkg::*;
#(
    parameter int NIB   = 4,
    parameter int DEPTH = 8
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           vld_i,
    input  alu_op_e        op_i,
    input  logic           fwd_a_i,
    input  logic           fwd_b_i,
    input  logic [NIB-1:0] a_i,
    input  logic [NIB-1:0] b_i,
    input  logic           cin_i,
    output logic           cfast_o,
    output logic           vld_o,
    output alu_op_e        op_o,
    output logic [NIB-1:0] res_o,
    output logic           cout_o,
    output logic           lt_o
);

    typedef struct packed {
        logic           vld;
        alu_op_e        op;
        logic [NIB-1:0] val;
        logic           cy;
        logic           lt;
    } stage_t;

    stage_t         pipe_q [DEPTH];
    stage_t         head;
    logic [NIB-1:0] opa, opb, bx, lv;
    logic [NIB:0]   sum_u;
    logic           inv, add, cfast_q;

    // Operand select, adder and logic unit for the slice's first stage.
    always_comb begin
        opa   = fwd_a_i ? pipe_q[DEPTH-1].val : a_i;
        opb   = fwd_b_i ? pipe_q[DEPTH-1].val : b_i;
        inv   = op_inverts_b(op_i);
        add   = op_uses_adder(op_i);
        bx    = inv ? ~opb : opb;
        sum_u = {1'b0, opa} + {1'b0, bx} + {{NIB{1'b0}}, cin_i};
        case (op_i)
            OP_AND:  lv = opa & opb;
            OP_OR:   lv = opa | opb;
            OP_XOR:  lv = opa ^ opb;
            OP_NOR:  lv = ~(opa | opb);
            default: lv = sum_u[NIB-1:0];
        endcase
        head.vld = vld_i;
        head.op  = op_i;
        head.val = lv;
        head.cy  = add & sum_u[NIB];
        // Sign of the sign-extended sum, which is the exact signed less-than.
        head.lt  = opa[NIB-1] ^ bx[NIB-1] ^ sum_u[NIB];
    end

    // Fast carry toward the next slice, ready when that slice starts.
    always_ff @(posedge clk) begin
        if (!rst_n) cfast_q <= 1'b0;
        else        cfast_q <= add & sum_u[NIB];
    end

    // Result pipeline that sets the slice depth.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
        end else begin
            pipe_q[0] <= head;
            for (int i = 1; i < DEPTH; i++) pipe_q[i] <= pipe_q[i-1];
        end
    end

    assign cfast_o = cfast_q;
    assign vld_o   = pipe_q[DEPTH-1].vld;
    assign op_o    = pipe_q[DEPTH-1].op;
    assign res_o   = pipe_q[DEPTH-1].val;
    assign cout_o  = pipe_q[DEPTH-1].cy;
    assign lt_o    = pipe_q[DEPTH-1].lt;

endmodule

// File: rtl/bsk_alu.sv
// Staggered 32-bit ALU top level: input skew lines, the slice chain, result
// de-skew, and the registered output stage that resolves flags.
// Assumes a forward select is raised only when a valid producer issued exactly
// DEPTH cycles earlier. Latency to the aligned output is SLICES+DEPTH.
module bsk_alu
    import bsk_alu_pkg::*;
#(
    parameter int NIB    = 4,
    parameter int SLICES = 8,
    parameter int DEPTH  = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    vld_i,
    input  logic [2:0]              op_i,
    input  logic                    fwd_a_i,
    input  logic                    fwd_b_i,
    input  logic [NIB*SLICES-1:0]   a_i,
    input  logic [NIB*SLICES-1:0]   b_i,
    output logic [SLICES-1:0]       skew_vld_o,
    output logic [NIB*SLICES-1:0]   skew_res_o,
    output logic                    vld_o,
    output logic [NIB*SLICES-1:0]   res_o,
    output logic                    cout_o
);

    localparam int W    = NIB * SLICES;
    localparam int LAST = SLICES - 1;
    localparam int LAT  = SLICES + DEPTH;

    typedef struct packed {
        logic           vld;
        logic [2:0]     op;
        logic           fa;
        logic           fb;
        logic [NIB-1:0] a;
        logic [NIB-1:0] b;
    } lane_t;

    lane_t          lane_in [SLICES];
    lane_t          lane_at [SLICES];
    logic           sl_cin  [SLICES];
    logic           sl_cf   [SLICES];
    logic           sl_vld  [SLICES];
    alu_op_e        sl_op   [SLICES];
    logic [NIB-1:0] sl_res  [SLICES];
    logic           sl_cout [SLICES];
    logic           sl_lt   [SLICES];
    logic [NIB-1:0] al_res  [SLICES];
    logic [W-1:0]   raw;

    logic           out_vld_q;
    alu_op_e        out_op_q;
    logic [W-1:0]   out_res_q;
    logic           out_cy_q;

    for (genvar k = 0; k < SLICES; k++) begin : g_slice
        // Bundle slice k's share of the issue.
        assign lane_in[k] = '{vld: vld_i, op: op_i, fa: fwd_a_i, fb: fwd_b_i,
                              a: a_i[k*NIB +: NIB], b: b_i[k*NIB +: NIB]};

        if (k == 0) begin : g_head
            assign lane_at[k] = lane_in[k];
            assign sl_cin[k]  = op_inverts_b(alu_op_e'(lane_at[k].op));
        end else begin : g_tail
            bsk_skew_line #(.WIDTH($bits(lane_t)), .STAGES(k)) u_skew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (lane_in[k]),
                .q     (lane_at[k])
            );
            assign sl_cin[k] = sl_cf[k-1];
        end

        bsk_alu_slice #(.NIB(NIB), .DEPTH(DEPTH)) u_slice (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_i   (lane_at[k].vld),
            .op_i    (alu_op_e'(lane_at[k].op)),
            .fwd_a_i (lane_at[k].fa),
            .fwd_b_i (lane_at[k].fb),
            .a_i     (lane_at[k].a),
            .b_i     (lane_at[k].b),
            .cin_i   (sl_cin[k]),
            .cfast_o (sl_cf[k]),
            .vld_o   (sl_vld[k]),
            .op_o    (sl_op[k]),
            .res_o   (sl_res[k]),
            .cout_o  (sl_cout[k]),
            .lt_o    (sl_lt[k])
        );

        // Hold earlier nibbles back until the last slice has finished.
        if (k == LAST) begin : g_al_direct
            assign al_res[k] = sl_res[k];
        end else begin : g_al_delay
            bsk_skew_line #(.WIDTH(NIB), .STAGES(LAST - k)) u_deskew (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (sl_res[k]),
                .q     (al_res[k])
            );
        end

        assign skew_vld_o[k]            = sl_vld[k];
        assign skew_res_o[k*NIB +: NIB] = sl_res[k];
    end

    // Gather the re-aligned nibbles into one word.
    always_comb begin
        raw = '0;
        for (int k = 0; k < SLICES; k++) raw[k*NIB +: NIB] = al_res[k];
    end

    // Output stage: turn the difference into a flag for SLT and EQ.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld_q <= 1'b0;
            out_op_q  <= OP_ADD;
            out_res_q <= '0;
            out_cy_q  <= 1'b0;
        end else begin
            out_vld_q <= sl_vld[LAST];
            out_op_q  <= sl_op[LAST];
            out_cy_q  <= sl_cout[LAST];
            case (sl_op[LAST])
                OP_SLT:  out_res_q <= {{(W-1){1'b0}}, sl_lt[LAST]};
                OP_EQ:   out_res_q <= {{(W-1){1'b0}}, (raw == '0)};
                default: out_res_q <= raw;
            endcase
        end
    end

    assign vld_o  = out_vld_q;
    assign res_o  = out_res_q;
    assign cout_o = out_cy_q;

endmodule

// File: rtl/bsk_alu_checker.sv
// Property checker for the staggered ALU, attached to every instance by bind.
// Assumes reset is held for at least two clock edges.
module bsk_alu_checker #(
    parameter int SLICES = 8,
    parameter int W      = 32,
    parameter int LAT    = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              vld_i,
    input logic [SLICES-1:0] skew_vld,
    input logic              vld_o,
    input logic [W-1:0]      res_o,
    input logic              cout_o,
    input logic [2:0]        op_q
);

    logic [LAT-1:0] vq;

    // Reference history of issue strobes, LAT deep.
    always_ff @(posedge clk) begin
        if (!rst_n) vq <= '0;
        else        vq <= {vq[LAT-2:0], vld_i};
    end

    // R2: aligned valid trails the issue strobe by exactly LAT edges.
    a_r2_aligned_latency: assert property (@(posedge clk) disable iff (!rst_n)
        vld_o == vq[LAT-1]);

    for (genvar k = 1; k < SLICES; k++) begin : g_step
        // R1: each slice's valid follows its neighbour by one cycle.
        a_r1_skew_step: assert property (@(posedge clk) disable iff (!rst_n)
            skew_vld[k] == $past(skew_vld[k-1]));
    end

    // R5: a less-than result carries no bits above bit 0.
    a_r5_slt_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && op_q == 3'd2) |-> (res_o[W-1:1] == '0));

    // R6: an equality result carries no bits above bit 0.
    a_r6_eq_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && op_q == 3'd3) |-> (res_o[W-1:1] == '0));

    // R7: logic operations never report a carry.
    a_r7_logic_no_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (vld_o && op_q[2]) |-> !cout_o);

endmodule

bind bsk_alu bsk_alu_checker #(.SLICES(SLICES), .W(W), .LAT(LAT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .vld_i    (vld_i),
    .skew_vld (skew_vld_o),
    .vld_o    (vld_o),
    .res_o    (res_o),
    .cout_o   (cout_o),
    .op_q     (out_op_q)
);

// File: tb/bsk_alu_bench.sv
// Self-checking bench: directed corner cases, then random back-to-back and
// gapped traffic with forwarding, all compared against a behavioural model.
module bsk_alu_bench;

    localparam int PERIOD = 10;
    localparam int LAT    = 16;
    localparam int SDEP   = 8;
    localparam int HN     = 2048;

    localparam logic [2:0] ADD = 3'd0, SUB = 3'd1, SLT = 3'd2, EQ = 3'd3,
                           AND = 3'd4, OR = 3'd5, XOR = 3'd6, NOR = 3'd7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vld_i = 1'b0;
    logic [2:0]  op_i = '0;
    logic        fwd_a_i = 1'b0, fwd_b_i = 1'b0;
    logic [31:0] a_i = '0, b_i = '0;
    logic [7:0]  skew_vld_o;
    logic [31:0] skew_res_o, res_o;
    logic        vld_o, cout_o;

    int checks = 0, errs = 0, cyc = 0, issued = 0, seen = 0;
    logic        hv   [HN];
    logic [31:0] hraw [HN];
    logic [31:0] hfin [HN];
    logic        hc   [HN];
    string       htag [HN];

    bsk_alu u_bsk_alu (
        .clk(clk), .rst_n(rst_n), .vld_i(vld_i), .op_i(op_i),
        .fwd_a_i(fwd_a_i), .fwd_b_i(fwd_b_i), .a_i(a_i), .b_i(b_i),
        .skew_vld_o(skew_vld_o), .skew_res_o(skew_res_o),
        .vld_o(vld_o), .res_o(res_o), .cout_o(cout_o)
    );

    always #(PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc = cyc + 1;

    function automatic logic [31:0] f_raw(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        case (op)
            ADD:      return a + b;
            SUB, SLT, EQ: return a - b;
            AND:      return a & b;
            OR:       return a | b;
            XOR:      return a ^ b;
            default:  return ~(a | b);
        endcase
    endfunction

    function automatic logic [31:0] f_fin(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        if (op == SLT) return {31'b0, $signed(a) < $signed(b)};
        if (op == EQ)  return {31'b0, a == b};
        return f_raw(op, a, b);
    endfunction

    function automatic logic f_cout(logic [2:0] op, logic [31:0] a, logic [31:0] b);
        logic [32:0] s;
        if (op == ADD) s = {1'b0, a} + {1'b0, b};
        else if (op == SUB || op == SLT || op == EQ) s = {1'b0, a} + {1'b0, ~b} + 33'd1;
        else s = '0;
        return s[32];
    endfunction

    function automatic logic [31:0] pick_val();
        case ($urandom % 8)
            0: return 32'h0000_0000;
            1: return 32'hFFFF_FFFF;
            2: return 32'h8000_0000;
            3: return 32'h7FFF_FFFF;
            default: return $urandom;
        endcase
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: got %h expected %h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Compare every output against the history recorded at issue time.
    task automatic observe();
        int i, j;
        i = cyc - LAT;
        if (i >= 0) begin
            chk("R2", {31'b0, vld_o}, {31'b0, hv[i]});
            if (hv[i]) begin
                chk(htag[i], res_o, hfin[i]);
                chk("R7", {31'b0, cout_o}, {31'b0, hc[i]});
            end
        end
        if (vld_o === 1'b1) seen++;
        for (int k = 0; k < 8; k++) begin
            j = cyc - SDEP - k;
            if (j >= 0) begin
                chk("R1", {31'b0, skew_vld_o[k]}, {31'b0, hv[j]});
                if (hv[j]) chk("R1", {28'b0, skew_res_o[k*4 +: 4]}, {28'b0, hraw[j][k*4 +: 4]});
            end
        end
    endtask

    // One cycle: check outputs, then record and drive the next issue.
    task automatic step(input logic v, input logic [2:0] op, input logic fa,
                        input logic fb, input logic [31:0] a, input logic [31:0] b,
                        input string tag);
        logic ua, ub;
        logic [31:0] ea, eb;
        @(negedge clk);
        observe();
        ua = fa && v && cyc >= SDEP && hv[cyc-SDEP];
        ub = fb && v && cyc >= SDEP && hv[cyc-SDEP];
        ea = ua ? hraw[cyc-SDEP] : a;
        eb = ub ? hraw[cyc-SDEP] : b;
        hv[cyc]   = v;
        hraw[cyc] = f_raw(op, ea, eb);
        hfin[cyc] = f_fin(op, ea, eb);
        hc[cyc]   = f_cout(op, ea, eb);
        if (tag != "")      htag[cyc] = tag;
        else if (ua || ub)  htag[cyc] = "R8";
        else if (op == SLT) htag[cyc] = "R5";
        else if (op == EQ)  htag[cyc] = "R6";
        else                htag[cyc] = "R4";
        if (v) issued++;
        vld_i = v; op_i = op; fwd_a_i = ua; fwd_b_i = ub; a_i = a; b_i = b;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) step(1'b0, ADD, 1'b0, 1'b0, '0, '0, "");
    endtask

    initial begin
        for (int i = 0; i < HN; i++) begin hv[i] = 1'b0; htag[i] = ""; end
        void'($urandom(32'd20240611));
        repeat (4) @(negedge clk);
        // R10: state while reset is applied.
        chk("R10", {31'b0, vld_o}, 32'd0);
        chk("R10", {24'b0, skew_vld_o}, 32'd0);
        chk("R10", res_o, 32'd0);
        rst_n = 1'b1;

        // Directed corner cases.
        step(1, ADD, 0, 0, 32'hFFFF_FFFF, 32'h1, "R9");
        step(1, ADD, 0, 0, 32'h0FFF_FFFF, 32'h0000_0001, "R9");
        step(1, SUB, 0, 0, 32'h0, 32'h1, "R4");
        step(1, SUB, 0, 0, 32'h5, 32'h5, "R4");
        step(1, SLT, 0, 0, 32'h8000_0000, 32'h1, "R5");
        step(1, SLT, 0, 0, 32'h1, 32'h8000_0000, "R5");
        step(1, SLT, 0, 0, 32'h7FFF_FFFF, 32'h8000_0000, "R5");
        step(1, SLT, 0, 0, 32'h8000_0000, 32'h7FFF_FFFF, "R5");
        step(1, SLT, 0, 0, 32'h3, 32'h3, "R5");
        step(1, EQ,  0, 0, 32'hDEAD_BEEF, 32'hDEAD_BEEF, "R6");
        step(1, EQ,  0, 0, 32'h1EAD_BEEF, 32'hDEAD_BEEF, "R6");
        step(1, AND, 0, 0, 32'hF0F0_1234, 32'hFF00_FF0F, "R4");
        step(1, OR,  0, 0, 32'hF0F0_1234, 32'h0F00_0008, "R4");
        step(1, XOR, 0, 0, 32'hAAAA_5555, 32'hFFFF_0000, "R4");
        step(1, NOR, 0, 0, 32'h0000_FFFF, 32'h00FF_0000, "R4");
        idle(20);

        // R8: dependent chain at the minimum spacing of eight cycles.
        step(1, ADD, 0, 0, 32'h0FFF_FFFE, 32'h1, "R8");
        for (int n = 0; n < 6; n++) begin
            idle(SDEP - 1);
            step(1, (n % 2) ? SUB : ADD, 1, n == 3, 32'hFFFF_FFFF, 32'h3, "R8");
        end
        idle(20);

        // R3: random independent ops every cycle, with random forwarding.
        for (int n = 0; n < 400; n++)
            step(1, 3'($urandom % 8), ($urandom % 4) == 0, ($urandom % 4) == 0,
                 pick_val(), pick_val(), "");
        // Gapped traffic: forwarding only taken when a producer exists.
        for (int n = 0; n < 300; n++)
            step(1'($urandom % 2), 3'($urandom % 8), ($urandom % 3) == 0,
                 ($urandom % 3) == 0, pick_val(), pick_val(), "");
        idle(LAT + 8);
        // R3: exactly one aligned result per issue.
        chk("R3", seen, issued);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

    initial begin
        #(PERIOD * 100000);
        errs++;
        checks++;
        $display("FAIL R3: watchdog expired, got %0d results expected %0d", seen, issued);
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule